// File: doc/BRIEF.md
# Transfer Descriptor Completion Write-back Sequencer

This block is the bus-master sequencer that a USB device controller runs once all data for one endpoint transfer descriptor has moved. A single start pulse hands it the descriptor base address, the queue-head base address, the updated descriptor and queue-head words, an interrupt-on-complete flag and a transfer-mode select. The block then writes the updated state back to memory, reads the descriptor's next-link word and raises the completion interrupt.

Descriptor layout: the next-link word sits at offset 0, the status word (holding the Active flag) at offset 4, and two further state words at offsets 8 and 12. The queue head takes three words at offsets 0, 4 and 8. Software may free a descriptor as soon as it sees Active clear. The block therefore writes the status word last, after the link re-read has returned. The fixed beat order is: descriptor +8, descriptor +12, queue head +0, +4, +8, a single-beat read of descriptor +0, and finally descriptor +4 with Active cleared.

In single mode every beat is a separate single transfer. In burst mode the two descriptor words form one incrementing burst and the three queue-head words form a second burst. The link read and the status write stay single beats in both modes.

Top module: `xfer_desc_retire`

## Requirements
- R1: After synchronous reset the block is idle: `busy_o`, `bus_req_o`, `irq_o`, `start_err_o`, `next_valid_o` and `list_end_o` are all 0.
- R2: A sequence consists of exactly seven accepted bus beats, in this order: descriptor base +8 (write), +12 (write), queue-head base +0, +4, +8 (writes), descriptor base +0 (read), descriptor base +4 (write). In single mode (`burst_mode_i`=0) every beat has `bus_burst_o`=0 and `bus_seq_o`=0.
- R3: In burst mode (`burst_mode_i`=1), beats 1 and 2 carry `bus_burst_o`=1 with `bus_seq_o` 0 then 1. Beats 3 to 5 carry `bus_burst_o`=1 with `bus_seq_o` 0, 1, 1. The read beat and the final status write carry `bus_burst_o`=0 and `bus_seq_o`=0.
- R4: The status word is written only as the seventh beat, after the link read has completed. Its data is the supplied status word with bit 7 (Active) forced to 0 and all other bits unchanged.
- R5: The data of the other write beats equals, in order, descriptor word 2, descriptor word 3, and queue-head words 0, 1, 2, as latched at start.
- R6: While `bus_req_o`=1 and `bus_ready_i`=0, the next cycle keeps `bus_req_o`=1 and keeps `bus_addr_o`, `bus_write_o` and `bus_wdata_o` unchanged.
- R7: In the cycle after the seventh beat is accepted, `irq_o` is 1 for exactly one cycle if `ioc_i` was 1 at start. Otherwise `irq_o` stays 0.
- R8: In that same final cycle, if bit 0 of the read link word is 1, `list_end_o` pulses. Otherwise `next_valid_o` pulses and `next_ptr_o` equals the link word with its low 5 bits cleared. The two pulses never coincide.
- R9: `busy_o` is 1 from the cycle after an accepted start through the final cycle, and 0 in the cycle after that.
- R10: A start request while `busy_o`=1 is ignored: the beat sequence and the data already latched are unaffected. `start_err_o` is 1 in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when idle |
| burst_mode_i | input | 1 | 1 = incrementing bursts, 0 = single beats |
| ioc_i | input | 1 | Interrupt-on-complete enable |
| dsc_base_i | input | AW | Descriptor base address |
| qh_base_i | input | AW | Queue-head base address |
| dsc_stat_i | input | DW | Updated status word (Active at bit 7) |
| dsc_w2_i | input | DW | Updated descriptor word at +8 |
| dsc_w3_i | input | DW | Updated descriptor word at +12 |
| qh_w0_i | input | DW | Queue-head word at +0 |
| qh_w1_i | input | DW | Queue-head word at +4 |
| qh_w2_i | input | DW | Queue-head word at +8 |
| bus_req_o | output | 1 | Beat request valid |
| bus_write_o | output | 1 | 1 = write beat, 0 = read beat |
| bus_burst_o | output | 1 | Beat belongs to an incrementing burst |
| bus_seq_o | output | 1 | Beat continues a burst (not its first beat) |
| bus_addr_o | output | AW | Beat address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data |
| bus_ready_i | input | 1 | Beat accepted this cycle |
| busy_o | output | 1 | Sequence in progress |
| irq_o | output | 1 | Completion interrupt pulse |
| next_valid_o | output | 1 | Next descriptor pointer valid pulse |
| next_ptr_o | output | AW | Next descriptor pointer |
| list_end_o | output | 1 | Terminate pulse: no further descriptor |
| start_err_o | output | 1 | Start request rejected while busy |

## Verification
The sequence is run in both modes, with `bus_ready_i` held high and with `bus_ready_i` dropped at random. The first case fixes the exact beat order. The second shows whether address, control and data stay frozen under wait states. Link words are varied between terminate-flagged and real pointers with junk in the low bits. This separates the end-of-list pulse from the pointer pulse and shows whether the alignment mask is applied. Status words with the Active bit both set and clear, a start pulse injected mid-sequence, and inputs scrambled after start together confirm that only latched values reach the bus and that the status write stays last.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    typedef enum logic [2:0] {
        DS_DW2  = 3'd0,
        DS_DW3  = 3'd1,
        DS_QW0  = 3'd2,
        DS_QW1  = 3'd3,
        DS_QW2  = 3'd4,
        DS_STAT = 3'd5,
        DS_NONE = 3'd6
    } data_sel_e;

    typedef struct packed {
        logic      to_qh;
        logic [3:0] offs;
        logic      write;
        logic      in_burst;
        logic      cont;
        data_sel_e dsel;
    } beat_ctl_t;

    localparam int NUM_BEATS = 7;
    localparam int BEAT_W    = 3;
    localparam logic [BEAT_W-1:0] BEAT_LINK = 3'd5;
    localparam logic [BEAT_W-1:0] BEAT_STAT = 3'd6;

    function automatic beat_ctl_t plan_beat(input logic [BEAT_W-1:0] idx,
                                            input logic burst);
        beat_ctl_t c;
        c = '{to_qh: 1'b0, offs: 4'd0, write: 1'b1, in_burst: 1'b0,
              cont: 1'b0, dsel: DS_NONE};
        case (idx)
            3'd0: begin c.offs = 4'd8;  c.dsel = DS_DW2; c.in_burst = burst; end
            3'd1: begin c.offs = 4'd12; c.dsel = DS_DW3; c.in_burst = burst; c.cont = burst; end
            3'd2: begin c.to_qh = 1'b1; c.offs = 4'd0; c.dsel = DS_QW0; c.in_burst = burst; end
            3'd3: begin c.to_qh = 1'b1; c.offs = 4'd4; c.dsel = DS_QW1; c.in_burst = burst; c.cont = burst; end
            3'd4: begin c.to_qh = 1'b1; c.offs = 4'd8; c.dsel = DS_QW2; c.in_burst = burst; c.cont = burst; end
            3'd5: begin c.offs = 4'd0; c.write = 1'b0; end
            default: begin c.offs = 4'd4; c.dsel = DS_STAT; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xdr_beat_plan.sv
module xdr_beat_plan
    import xdr_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              burst_i,
    input  logic [AW-1:0]     dsc_base_i,
    input  logic [AW-1:0]     qh_base_i,
    input  logic [DW-1:0]     stat_i,
    input  logic [DW-1:0]     dw2_i,
    input  logic [DW-1:0]     dw3_i,
    input  logic [DW-1:0]     qw0_i,
    input  logic [DW-1:0]     qw1_i,
    input  logic [DW-1:0]     qw2_i,
    output logic [AW-1:0]     addr_o,
    output logic              write_o,
    output logic              burst_o,
    output logic              seq_o,
    output logic [DW-1:0]     wdata_o
);
    beat_ctl_t ctl;
    logic [AW-1:0] base;

    always_comb begin
        ctl     = plan_beat(beat_i, burst_i);
        base    = ctl.to_qh ? qh_base_i : dsc_base_i;
        addr_o  = base + AW'(ctl.offs);
        write_o = ctl.write;
        burst_o = ctl.in_burst;
        seq_o   = ctl.cont;
        case (ctl.dsel)
            DS_DW2:  wdata_o = dw2_i;
            DS_DW3:  wdata_o = dw3_i;
            DS_QW0:  wdata_o = qw0_i;
            DS_QW1:  wdata_o = qw1_i;
            DS_QW2:  wdata_o = qw2_i;
            DS_STAT: wdata_o = stat_i;
            default: wdata_o = '0;
        endcase
    end
endmodule

// File: rtl/xdr_link_eval.sv
module xdr_link_eval #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int TERM_BIT   = 0,
    parameter int LINK_ALIGN = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          fin_i,
    output logic          next_valid_o,
    output logic          list_end_o,
    output logic [AW-1:0] next_ptr_o
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << LINK_ALIGN) - AW'(1));

    logic [DW-1:0] link_q;

    always_ff @(posedge clk) begin
        if (rst)        link_q <= '0;
        else if (cap_i) link_q <= rdata_i;
    end

    assign list_end_o   = fin_i &  link_q[TERM_BIT];
    assign next_valid_o = fin_i & ~link_q[TERM_BIT];
    assign next_ptr_o   = AW'(link_q) & ALIGN_MASK;

    p_link_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(next_valid_o && list_end_o));

    p_link_fin_r8: assert property (@(posedge clk) disable iff (rst)
        (next_valid_o || list_end_o) |=> !(next_valid_o || list_end_o));
endmodule

// File: rtl/xfer_desc_retire.sv
module xfer_desc_retire
    import xdr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int ACTIVE_BIT = 7,
    parameter int TERM_BIT   = 0,
    parameter int LINK_ALIGN = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          burst_mode_i,
    input  logic          ioc_i,
    input  logic [AW-1:0] dsc_base_i,
    input  logic [AW-1:0] qh_base_i,
    input  logic [DW-1:0] dsc_stat_i,
    input  logic [DW-1:0] dsc_w2_i,
    input  logic [DW-1:0] dsc_w3_i,
    input  logic [DW-1:0] qh_w0_i,
    input  logic [DW-1:0] qh_w1_i,
    input  logic [DW-1:0] qh_w2_i,
    output logic          bus_req_o,
    output logic          bus_write_o,
    output logic          bus_burst_o,
    output logic          bus_seq_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_ready_i,
    output logic          busy_o,
    output logic          irq_o,
    output logic          next_valid_o,
    output logic [AW-1:0] next_ptr_o,
    output logic          list_end_o,
    output logic          start_err_o
);
    localparam logic [DW-1:0] ACTIVE_MASK = DW'(1) << ACTIVE_BIT;

    seq_st_e           st_q;
    logic [BEAT_W-1:0] beat_q;
    logic              burst_q, ioc_q, err_q;
    logic [AW-1:0]     dsc_base_q, qh_base_q;
    logic [DW-1:0]     stat_q, dw2_q, dw3_q, qw0_q, qw1_q, qw2_q;
    logic              accept, beat_done, link_cap;

    assign accept    = (st_q == ST_IDLE) && start_i;
    assign beat_done = (st_q == ST_RUN) && bus_ready_i;
    assign link_cap  = beat_done && (beat_q == BEAT_LINK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= start_i && (st_q != ST_IDLE);
            case (st_q)
                ST_IDLE: if (accept) begin
                    st_q   <= ST_RUN;
                    beat_q <= '0;
                end
                ST_RUN: if (beat_done) begin
                    if (beat_q == BEAT_STAT) st_q <= ST_FIN;
                    else                     beat_q <= beat_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q    <= 1'b0;
            ioc_q      <= 1'b0;
            dsc_base_q <= '0;
            qh_base_q  <= '0;
            stat_q     <= '0;
            dw2_q      <= '0;
            dw3_q      <= '0;
            qw0_q      <= '0;
            qw1_q      <= '0;
            qw2_q      <= '0;
        end else if (accept) begin
            burst_q    <= burst_mode_i;
            ioc_q      <= ioc_i;
            dsc_base_q <= dsc_base_i;
            qh_base_q  <= qh_base_i;
            stat_q     <= dsc_stat_i & ~ACTIVE_MASK;
            dw2_q      <= dsc_w2_i;
            dw3_q      <= dsc_w3_i;
            qw0_q      <= qh_w0_i;
            qw1_q      <= qh_w1_i;
            qw2_q      <= qh_w2_i;
        end
    end

    xdr_beat_plan #(.AW(AW), .DW(DW)) i_plan (
        .beat_i     (beat_q),
        .burst_i    (burst_q),
        .dsc_base_i (dsc_base_q),
        .qh_base_i  (qh_base_q),
        .stat_i     (stat_q),
        .dw2_i      (dw2_q),
        .dw3_i      (dw3_q),
        .qw0_i      (qw0_q),
        .qw1_i      (qw1_q),
        .qw2_i      (qw2_q),
        .addr_o     (bus_addr_o),
        .write_o    (bus_write_o),
        .burst_o    (bus_burst_o),
        .seq_o      (bus_seq_o),
        .wdata_o    (bus_wdata_o)
    );

    xdr_link_eval #(.AW(AW), .DW(DW), .TERM_BIT(TERM_BIT), .LINK_ALIGN(LINK_ALIGN)) i_link (
        .clk          (clk),
        .rst          (rst),
        .cap_i        (link_cap),
        .rdata_i      (bus_rdata_i),
        .fin_i        (st_q == ST_FIN),
        .next_valid_o (next_valid_o),
        .list_end_o   (list_end_o),
        .next_ptr_o   (next_ptr_o)
    );

    assign bus_req_o   = (st_q == ST_RUN);
    assign busy_o      = (st_q != ST_IDLE);
    assign irq_o       = (st_q == ST_FIN) && ioc_q;
    assign start_err_o = err_q;

    p_hold_beat_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                        $stable(bus_write_o) && $stable(bus_wdata_o)));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    p_irq_after_stat_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(bus_req_o && bus_write_o && bus_ready_i));

    p_req_busy_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |-> busy_o);

    p_err_busy_r10: assert property (@(posedge clk) disable iff (rst)
        start_err_o |-> $past(busy_o));
endmodule

// File: tb/test_xfer_desc_retire.sv
module test_xfer_desc_retire;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, start_i, burst_mode_i, ioc_i, bus_ready_i;
    logic [31:0] dsc_base_i, qh_base_i, dsc_stat_i, dsc_w2_i, dsc_w3_i;
    logic [31:0] qh_w0_i, qh_w1_i, qh_w2_i, bus_rdata_i;
    logic        bus_req_o, bus_write_o, bus_burst_o, bus_seq_o;
    logic [31:0] bus_addr_o, bus_wdata_o, next_ptr_o;
    logic        busy_o, irq_o, next_valid_o, list_end_o, start_err_o;

    xfer_desc_retire i_xfer_desc_retire (.*);

    int nvec = 0;
    int nbad = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic exp_beat(input int i, input bit bm, input logic [31:0] da,
                            input logic [31:0] qa, input logic [31:0] w[6],
                            output logic [31:0] a, output bit wr, output bit bu,
                            output bit sq, output logic [31:0] d);
        wr = 1'b1; bu = 1'b0; sq = 1'b0; d = 32'h0;
        case (i)
            0: begin a = da + 8;  d = w[1]; bu = bm; end
            1: begin a = da + 12; d = w[2]; bu = bm; sq = bm; end
            2: begin a = qa;      d = w[3]; bu = bm; end
            3: begin a = qa + 4;  d = w[4]; bu = bm; sq = bm; end
            4: begin a = qa + 8;  d = w[5]; bu = bm; sq = bm; end
            5: begin a = da;      wr = 1'b0; end
            default: begin a = da + 4; d = w[0] & ~32'h80; end
        endcase
    endtask

    task automatic scramble();
        dsc_base_i = $urandom; qh_base_i = $urandom; dsc_stat_i = $urandom;
        dsc_w2_i = $urandom; dsc_w3_i = $urandom; qh_w0_i = $urandom;
        qh_w1_i = $urandom; qh_w2_i = $urandom;
        burst_mode_i = $urandom % 2; ioc_i = $urandom % 2;
    endtask

    task automatic run_seq(input bit bm, input bit ioc, input logic [31:0] link,
                           input logic [31:0] stat, input bit stall, input bit poke);
        logic [31:0] da, qa, w[6], ea, ed, pa, pd;
        bit ew, eb, es, stalled, err_exp, rdy, pw;
        int b, cyc;
        da = $urandom & 32'hFFFF_FFE0;
        qa = $urandom & 32'hFFFF_FFC0;
        w[0] = stat;
        for (int k = 1; k < 6; k++) w[k] = $urandom;
        @(negedge clk);
        dsc_base_i = da; qh_base_i = qa; dsc_stat_i = w[0]; dsc_w2_i = w[1];
        dsc_w3_i = w[2]; qh_w0_i = w[3]; qh_w1_i = w[4]; qh_w2_i = w[5];
        burst_mode_i = bm; ioc_i = ioc; bus_rdata_i = link; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        scramble();
        b = 0; cyc = 0; stalled = 0; err_exp = 0; pa = 0; pd = 0; pw = 0;
        while (b < 7 && cyc < 300) begin
            chk(busy_o == 1'b1, "R9 busy during run", 32'(busy_o), 32'd1);
            chk(start_err_o == err_exp, "R10 start_err", 32'(start_err_o), 32'(err_exp));
            err_exp = 0;
            if (stalled) begin
                chk(bus_addr_o == pa, "R6 addr held", bus_addr_o, pa);
                chk(bus_wdata_o == pd && bus_write_o == pw, "R6 data held", bus_wdata_o, pd);
            end
            exp_beat(b, bm, da, qa, w, ea, ew, eb, es, ed);
            chk(bus_req_o == 1'b1, "R2 req", 32'(bus_req_o), 32'd1);
            chk(bus_addr_o == ea, "R2 beat addr", bus_addr_o, ea);
            chk(bus_write_o == ew, "R2 beat dir", 32'(bus_write_o), 32'(ew));
            chk(bus_burst_o == eb && bus_seq_o == es, bm ? "R3 burst ctl" : "R2 single ctl",
                {30'd0, bus_burst_o, bus_seq_o}, {30'd0, eb, es});
            if (ew) chk(bus_wdata_o == ed, b == 6 ? "R4 status data" : "R5 write data",
                        bus_wdata_o, ed);
            rdy = stall ? (($urandom % 3) != 0) : 1'b1;
            bus_ready_i = rdy;
            if (poke && cyc == 1) begin start_i = 1'b1; err_exp = 1; end
            else start_i = 1'b0;
            stalled = !rdy; pa = bus_addr_o; pd = bus_wdata_o; pw = bus_write_o;
            if (rdy) b++;
            cyc++;
            @(negedge clk);
        end
        bus_ready_i = 1'b0; start_i = 1'b0;
        chk(b == 7, "R2 beat count", b, 7);
        chk(start_err_o == err_exp, "R10 start_err", 32'(start_err_o), 32'(err_exp));
        chk(bus_req_o == 1'b0, "R2 no eighth beat", 32'(bus_req_o), 32'd0);
        chk(irq_o == ioc, "R7 irq", 32'(irq_o), 32'(ioc));
        chk(busy_o == 1'b1, "R9 busy at end", 32'(busy_o), 32'd1);
        chk(list_end_o == link[0], "R8 list_end", 32'(list_end_o), 32'(link[0]));
        chk(next_valid_o == !link[0], "R8 next_valid", 32'(next_valid_o), 32'(!link[0]));
        if (!link[0]) chk(next_ptr_o == (link & 32'hFFFF_FFE0), "R8 next_ptr",
                          next_ptr_o, link & 32'hFFFF_FFE0);
        @(negedge clk);
        chk(busy_o == 1'b0, "R9 idle after", 32'(busy_o), 32'd0);
        chk(irq_o == 1'b0 && next_valid_o == 1'b0 && list_end_o == 1'b0, "R7 pulse ends",
            {29'd0, irq_o, next_valid_o, list_end_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; start_i = 1'b0; bus_ready_i = 1'b0; bus_rdata_i = '0;
        scramble();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, bus_req_o, irq_o, start_err_o, next_valid_o, list_end_o} == 6'd0,
            "R1 reset idle",
            {26'd0, busy_o, bus_req_o, irq_o, start_err_o, next_valid_o, list_end_o}, 32'd0);
        run_seq(1'b0, 1'b1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_seq(1'b1, 1'b0, 32'h1234_567E, 32'h0000_0080, 1'b0, 1'b0);
        run_seq(1'b0, 1'b1, 32'hABCD_EF1F, 32'h0000_0000, 1'b1, 1'b0);
        run_seq(1'b1, 1'b1, 32'h0000_0041, 32'h5A5A_A5A5, 1'b1, 1'b1);
        run_seq(1'b0, 1'b0, 32'hFFFF_FFE0, 32'h8000_0080, 1'b0, 1'b1);
        for (int n = 0; n < 40; n++)
            run_seq($urandom % 2, $urandom % 2, $urandom, $urandom,
                    $urandom % 2, $urandom % 2);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule